// File: doc/BRIEF.md
# Protected Memory Access Guard

This block sits on a memory request path, one stage before the memory controller. It checks every request against two guarded system-management regions. Guarded requests are not dropped. Each one leaves the block aimed at a fixed harmless safe address. A guarded write also leaves with its byte enables cleared, so that it stores nothing. Central processor requests that reach the guarded regions directly pass through. Requests from I/O agents or from the graphics engine are shielded. Any request that reached a guarded region through a graphics address-translation lookup is shielded and is also recorded.

The block applies three further checks:
- A translation-table fetch is rejected if its address is at or above the base of the top segment, or if it lies in the legacy window between 640 KB and 1 MB.
- An I/O-agent read that targets the graphics aperture is sent to the safe address and answered as an unsupported request.
- The first translated hit is captured in a sticky error record, which holds the requester class and the address. Software clears the record with a one-cycle strobe.

The block has one register stage and a valid/ready handshake on both sides. It accepts one request per cycle and keeps request order.

Top module: `prg_guard`

## Requirements
- R1: The compatible region 0x0A_0000..0x0B_FFFF (inclusive) is guarded only while `cfg_compat_en` is 1. While it is 0, requests to that range are treated as ordinary memory.
- R2: The top segment is guarded only while `cfg_tseg_en` is 1. It covers the addresses a with `cfg_tolm - cfg_stolen - cfg_tseg_size <= a < cfg_tolm - cfg_stolen`.
- R3: An untranslated request (`in_xlat`=0) to a guarded region from a source other than the CPU is redirected. The source codes are 0 CPU, 1 I/O agent, 2 graphics, 3 auxiliary. A redirected request leaves with address SAFE_ADDR (0x0C_0000). A write also has `out_be` forced to zero, and the status is 2'b00 (successful). No error is recorded.
- R4: A translated request (`in_xlat`=1) to a guarded region is redirected as in R3 for every source, and it is recorded in the error record.
- R5: An untranslated CPU request to a guarded region passes with its address and byte enables unchanged, status 2'b00, and no error.
- R6: An I/O-agent read with `cfg_aper_base <= addr < cfg_aper_limit` goes to SAFE_ADDR with status 2'b01 (unsupported request). Every other request reports 2'b00, including I/O writes to the aperture and redirected writes.
- R7: A table fetch (`in_fetch`=1) is redirected to SAFE_ADDR if its address is at or above the top-segment base, or if it lies in 0x0A_0000..0x0F_FFFF. This holds for any source and whatever the region enables are. A write fetch also has its byte enables cleared.
- R8: The error record (`err_valid`, `err_src`, `err_addr`) keeps the first recorded request until `err_clr` is pulsed. Later errors do not overwrite it. When `err_clr` and a new error arrive in the same cycle, the clear wins and the record ends empty.
- R9: An accepted request appears on the output one cycle after its acceptance edge. `in_ready` is 1 when the output stage is empty or is being drained. Under backpressure the output holds steady, and requests leave in the order they were accepted.
- R10: After reset `out_valid` and `err_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_compat_en | input | 1 | Guard the compatible region |
| cfg_tseg_en | input | 1 | Guard the top segment |
| cfg_tolm | input | AW | Top of low memory |
| cfg_stolen | input | AW | Size of memory reserved below the top of low memory |
| cfg_tseg_size | input | AW | Size of the top segment |
| cfg_aper_base | input | AW | Graphics aperture start (inclusive) |
| cfg_aper_limit | input | AW | Graphics aperture end (exclusive) |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted this cycle when valid |
| in_addr | input | AW | Request address |
| in_src | input | 2 | Source class: 0 CPU, 1 I/O, 2 graphics, 3 auxiliary |
| in_write | input | 1 | 1 write, 0 read |
| in_be | input | BEW | Byte enables |
| in_xlat | input | 1 | Address came from a translation lookup |
| in_fetch | input | 1 | Request is a translation-table fetch |
| out_valid | output | 1 | Checked request valid |
| out_ready | input | 1 | Downstream accepts |
| out_addr | output | AW | Possibly redirected address |
| out_src | output | 2 | Source class, passed through |
| out_write | output | 1 | Direction, passed through |
| out_be | output | BEW | Possibly cleared byte enables |
| out_status | output | 2 | 00 successful, 01 unsupported request |
| err_valid | output | 1 | Error record holds an entry |
| err_src | output | 2 | Source of the recorded request |
| err_addr | output | AW | Address of the recorded request |
| err_clr | input | 1 | Clear strobe for the error record |

## Verification
The bench builds the guard with AW=24 and BEW=4. Every guarded range, the aperture and the 1 MB legacy window then fit in a 16 MB space, and the edge addresses can be listed by hand. Three configurations are swept: both regions enabled, only the top segment enabled at a different place, and both disabled. For each one, every region and aperture edge ±1 is crossed with every source, direction, translation flag and fetch flag. Separate sequences cover first-error retention, a clear that collides with a capture, and ordering under backpressure.

// File: rtl/prg_pkg.sv
package prg_pkg;
   typedef enum logic [1:0] {
      SRC_CPU = 2'd0,
      SRC_IO  = 2'd1,
      SRC_GFX = 2'd2,
      SRC_AUX = 2'd3
   } src_e;

   localparam logic [1:0] ST_OK = 2'b00;
   localparam logic [1:0] ST_UR = 2'b01;

   localparam logic [31:0] COMPAT_LO = 32'h000A_0000;
   localparam logic [31:0] COMPAT_HI = 32'h000B_FFFF;
   localparam logic [31:0] LEGACY_HI = 32'h000F_FFFF;
   localparam logic [31:0] SAFE_DFLT = 32'h000C_0000;
endpackage

// File: rtl/prg_region_decode.sv
module prg_region_decode #(
   parameter int AW      = 32,
   parameter bit APER_EN = 1'b1
) (
   input  logic [AW-1:0] addr,
   input  logic          cfg_compat_en,
   input  logic          cfg_tseg_en,
   input  logic [AW-1:0] cfg_tolm,
   input  logic [AW-1:0] cfg_stolen,
   input  logic [AW-1:0] cfg_tseg_size,
   input  logic [AW-1:0] cfg_aper_base,
   input  logic [AW-1:0] cfg_aper_limit,
   output logic          hit_compat,
   output logic          hit_tseg,
   output logic          hit_aper,
   output logic          in_legacy,
   output logic          above_tbase
);
   import prg_pkg::*;

   localparam logic [AW-1:0] CMP_LO = AW'(COMPAT_LO);
   localparam logic [AW-1:0] CMP_HI = AW'(COMPAT_HI);
   localparam logic [AW-1:0] LEG_HI = AW'(LEGACY_HI);

   logic [AW-1:0] tseg_top;
   logic [AW-1:0] tseg_base;
   logic          in_cmp_range;
   logic          in_tseg_range;

   always_comb begin
      tseg_top      = cfg_tolm - cfg_stolen;
      tseg_base     = tseg_top - cfg_tseg_size;
      in_cmp_range  = (addr >= CMP_LO) && (addr <= CMP_HI);
      in_tseg_range = (addr >= tseg_base) && (addr < tseg_top);
      hit_compat    = cfg_compat_en && in_cmp_range;
      hit_tseg      = cfg_tseg_en && in_tseg_range;
      in_legacy     = (addr >= CMP_LO) && (addr <= LEG_HI);
      above_tbase   = (addr >= tseg_base);
   end

   generate
      if (APER_EN) begin : g_aper
         assign hit_aper = (addr >= cfg_aper_base) && (addr < cfg_aper_limit);
      end else begin : g_no_aper
         assign hit_aper = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/prg_policy.sv
module prg_policy #(
   parameter int              AW        = 32,
   parameter int              BEW       = 8,
   parameter logic [AW-1:0]   SAFE_ADDR = AW'(32'h000C_0000)
) (
   input  logic [AW-1:0]  addr,
   input  logic [1:0]     src,
   input  logic           write,
   input  logic [BEW-1:0] be,
   input  logic           xlat,
   input  logic           fetch,
   input  logic           hit_compat,
   input  logic           hit_tseg,
   input  logic           hit_aper,
   input  logic           in_legacy,
   input  logic           above_tbase,
   output logic [AW-1:0]  nxt_addr,
   output logic [BEW-1:0] nxt_be,
   output logic [1:0]     nxt_status,
   output logic           log_err
);
   import prg_pkg::*;

   logic guarded;
   logic foreign;
   logic fetch_bad;
   logic io_aper_rd;
   logic shield;
   logic redirect;

   always_comb begin
      guarded    = hit_compat | hit_tseg;
      foreign    = (src_e'(src) != SRC_CPU);
      fetch_bad  = fetch && (in_legacy || above_tbase);
      io_aper_rd = (src_e'(src) == SRC_IO) && !write && hit_aper;
      shield     = guarded && (foreign || xlat);
      redirect   = fetch_bad | io_aper_rd | shield;
      nxt_addr   = redirect ? SAFE_ADDR : addr;
      nxt_be     = (redirect && write) ? '0 : be;
      nxt_status = io_aper_rd ? ST_UR : ST_OK;
      log_err    = guarded && xlat;
   end
endmodule

// File: rtl/prg_out_stage.sv
module prg_out_stage #(
   parameter int PW = 40
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [PW-1:0] in_data,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [PW-1:0] out_data
);
   logic          vld_q;
   logic [PW-1:0] dat_q;

   assign in_ready  = !vld_q || out_ready;
   assign out_valid = vld_q;
   assign out_data  = dat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         dat_q <= '0;
      end else if (in_ready) begin
         vld_q <= in_valid;
         if (in_valid) dat_q <= in_data;
      end
   end
endmodule

// File: rtl/prg_err_log.sv
module prg_err_log #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture,
   input  logic [1:0]    cap_src,
   input  logic [AW-1:0] cap_addr,
   input  logic          clr,
   output logic          err_valid,
   output logic [1:0]    err_src,
   output logic [AW-1:0] err_addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_valid <= 1'b0;
         err_src   <= '0;
         err_addr  <= '0;
      end else if (clr) begin
         err_valid <= 1'b0;
      end else if (capture && !err_valid) begin
         err_valid <= 1'b1;
         err_src   <= cap_src;
         err_addr  <= cap_addr;
      end
   end
endmodule

// File: rtl/prg_guard.sv
module prg_guard #(
   parameter int            AW        = 32,
   parameter int            BEW       = 8,
   parameter bit            APER_EN   = 1'b1,
   parameter logic [AW-1:0] SAFE_ADDR = AW'(32'h000C_0000)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_compat_en,
   input  logic           cfg_tseg_en,
   input  logic [AW-1:0]  cfg_tolm,
   input  logic [AW-1:0]  cfg_stolen,
   input  logic [AW-1:0]  cfg_tseg_size,
   input  logic [AW-1:0]  cfg_aper_base,
   input  logic [AW-1:0]  cfg_aper_limit,
   input  logic           in_valid,
   output logic           in_ready,
   input  logic [AW-1:0]  in_addr,
   input  logic [1:0]     in_src,
   input  logic           in_write,
   input  logic [BEW-1:0] in_be,
   input  logic           in_xlat,
   input  logic           in_fetch,
   output logic           out_valid,
   input  logic           out_ready,
   output logic [AW-1:0]  out_addr,
   output logic [1:0]     out_src,
   output logic           out_write,
   output logic [BEW-1:0] out_be,
   output logic [1:0]     out_status,
   output logic           err_valid,
   output logic [1:0]     err_src,
   output logic [AW-1:0]  err_addr,
   input  logic           err_clr
);
   localparam int PW = AW + 2 + 1 + BEW + 2;

   generate
      if (AW < 21) begin : g_bad_aw
         $error("prg_guard: AW must cover the 1 MB legacy window");
      end
      if (BEW < 1 || (BEW & (BEW - 1)) != 0) begin : g_bad_bew
         $error("prg_guard: BEW must be a power of two");
      end
   endgenerate

   logic           hit_compat, hit_tseg, hit_aper, in_legacy, above_tbase;
   logic [AW-1:0]  nxt_addr;
   logic [BEW-1:0] nxt_be;
   logic [1:0]     nxt_status;
   logic           log_err;
   logic [PW-1:0]  pkt_in, pkt_out;

   prg_region_decode #(.AW(AW), .APER_EN(APER_EN)) decode_i (
      .addr          (in_addr),
      .cfg_compat_en (cfg_compat_en),
      .cfg_tseg_en   (cfg_tseg_en),
      .cfg_tolm      (cfg_tolm),
      .cfg_stolen    (cfg_stolen),
      .cfg_tseg_size (cfg_tseg_size),
      .cfg_aper_base (cfg_aper_base),
      .cfg_aper_limit(cfg_aper_limit),
      .hit_compat    (hit_compat),
      .hit_tseg      (hit_tseg),
      .hit_aper      (hit_aper),
      .in_legacy     (in_legacy),
      .above_tbase   (above_tbase)
   );

   prg_policy #(.AW(AW), .BEW(BEW), .SAFE_ADDR(SAFE_ADDR)) policy_i (
      .addr       (in_addr),
      .src        (in_src),
      .write      (in_write),
      .be         (in_be),
      .xlat       (in_xlat),
      .fetch      (in_fetch),
      .hit_compat (hit_compat),
      .hit_tseg   (hit_tseg),
      .hit_aper   (hit_aper),
      .in_legacy  (in_legacy),
      .above_tbase(above_tbase),
      .nxt_addr   (nxt_addr),
      .nxt_be     (nxt_be),
      .nxt_status (nxt_status),
      .log_err    (log_err)
   );

   assign pkt_in = {nxt_addr, in_src, in_write, nxt_be, nxt_status};

   prg_out_stage #(.PW(PW)) stage_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  (pkt_in),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_data (pkt_out)
   );

   assign {out_addr, out_src, out_write, out_be, out_status} = pkt_out;

   prg_err_log #(.AW(AW)) errlog_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (in_valid && in_ready && log_err),
      .cap_src  (in_src),
      .cap_addr (in_addr),
      .clr      (err_clr),
      .err_valid(err_valid),
      .err_src  (err_src),
      .err_addr (err_addr)
   );
endmodule

// File: rtl/prg_guard_chk.sv
module prg_guard_chk #(
   parameter int            AW        = 32,
   parameter int            BEW       = 8,
   parameter logic [AW-1:0] SAFE_ADDR = AW'(32'h000C_0000)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           cfg_compat_en,
   input logic           in_valid,
   input logic           in_ready,
   input logic [AW-1:0]  in_addr,
   input logic [1:0]     in_src,
   input logic           in_xlat,
   input logic           in_fetch,
   input logic           out_valid,
   input logic           out_ready,
   input logic [AW-1:0]  out_addr,
   input logic           out_write,
   input logic [BEW-1:0] out_be,
   input logic [1:0]     out_status,
   input logic           err_valid,
   input logic [AW-1:0]  err_addr,
   input logic           err_clr
);
   localparam logic [AW-1:0] CLO = AW'(32'h000A_0000);
   localparam logic [AW-1:0] CHI = AW'(32'h000B_FFFF);

   // R9: held output under backpressure
   a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_be) && $stable(out_status));

   // R9: an accepted request is presented on the next cycle
   a_r9_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);

   // R6: unsupported status only on a redirected read
   a_r6_ur_redirected: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_status == 2'b01 |-> out_addr == SAFE_ADDR && !out_write);

   // R6: status takes only the two defined codes
   a_r6_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_status inside {2'b00, 2'b01});

   // R3: no non-CPU request leaves aimed at an enabled compatible region
   a_r3_compat_shield: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_src != 2'd0 && cfg_compat_en |=> !(out_addr >= CLO && out_addr <= CHI));

   // R5: a plain CPU request keeps its address
   a_r5_cpu_passes: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_src == 2'd0 && !in_xlat && !in_fetch |=> out_addr == $past(in_addr));

   // R8: the record holds until cleared
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid && !err_clr |=> err_valid && $stable(err_addr));

   // R8: a clear empties the record
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr |=> !err_valid);
endmodule

bind prg_guard prg_guard_chk #(.AW(AW), .BEW(BEW), .SAFE_ADDR(SAFE_ADDR)) chk_i (
   .clk(clk), .rst_n(rst_n), .cfg_compat_en(cfg_compat_en),
   .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_src(in_src),
   .in_xlat(in_xlat), .in_fetch(in_fetch), .out_valid(out_valid), .out_ready(out_ready),
   .out_addr(out_addr), .out_write(out_write), .out_be(out_be), .out_status(out_status),
   .err_valid(err_valid), .err_addr(err_addr), .err_clr(err_clr)
);

// File: tb/prg_guard_tb_top.sv
module prg_guard_tb_top;
   localparam int AW  = 24;
   localparam int BEW = 4;
   localparam logic [AW-1:0] SAFE = 24'h0C_0000;
   localparam logic [BEW-1:0] BEP = 4'b1011;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic           cfg_compat_en = 1'b0, cfg_tseg_en = 1'b0;
   logic [AW-1:0]  cfg_tolm = '0, cfg_stolen = '0, cfg_tseg_size = '0;
   logic [AW-1:0]  cfg_aper_base = '0, cfg_aper_limit = '0;
   logic           in_valid = 1'b0, in_write = 1'b0, in_xlat = 1'b0, in_fetch = 1'b0;
   logic [AW-1:0]  in_addr = '0;
   logic [1:0]     in_src = '0;
   logic [BEW-1:0] in_be = '0;
   logic           out_ready = 1'b1, err_clr = 1'b0;
   logic           in_ready, out_valid, out_write, err_valid;
   logic [AW-1:0]  out_addr, err_addr;
   logic [1:0]     out_src, out_status, err_src;
   logic [BEW-1:0] out_be;

   int n_chk = 0;
   int n_bad = 0;

   prg_guard #(.AW(AW), .BEW(BEW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_compat_en(cfg_compat_en), .cfg_tseg_en(cfg_tseg_en),
      .cfg_tolm(cfg_tolm), .cfg_stolen(cfg_stolen), .cfg_tseg_size(cfg_tseg_size),
      .cfg_aper_base(cfg_aper_base), .cfg_aper_limit(cfg_aper_limit),
      .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_src(in_src),
      .in_write(in_write), .in_be(in_be), .in_xlat(in_xlat), .in_fetch(in_fetch),
      .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_src(out_src),
      .out_write(out_write), .out_be(out_be), .out_status(out_status),
      .err_valid(err_valid), .err_src(err_src), .err_addr(err_addr), .err_clr(err_clr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   endtask

   // expected results, from the requirements
   logic [AW-1:0] e_addr;
   logic [BEW-1:0] e_be;
   logic [1:0] e_st;
   logic e_log;

   task automatic model(input logic [AW-1:0] a, input logic [1:0] s, input bit w,
                        input bit x, input bit f);
      logic [AW-1:0] top, base;
      bit cmp, tsg, aper, leg, guard, redir, ur;
      top   = cfg_tolm - cfg_stolen;
      base  = top - cfg_tseg_size;
      cmp   = cfg_compat_en && a >= 24'h0A_0000 && a <= 24'h0B_FFFF;       // R1
      tsg   = cfg_tseg_en && a >= base && a < top;                          // R2
      aper  = a >= cfg_aper_base && a < cfg_aper_limit;
      leg   = a >= 24'h0A_0000 && a <= 24'h0F_FFFF;
      guard = cmp || tsg;
      ur    = (s == 2'd1) && !w && aper;                                    // R6
      redir = (f && (leg || a >= base)) || ur || (guard && (s != 2'd0 || x)); // R3 R4 R5 R7
      e_addr = redir ? SAFE : a;
      e_be   = (redir && w) ? '0 : BEP;
      e_st   = ur ? 2'b01 : 2'b00;
      e_log  = guard && x;
   endtask

   task automatic send(input logic [AW-1:0] a, input logic [1:0] s, input bit w,
                       input bit x, input bit f);
      @(negedge clk);
      in_valid = 1'b1; in_addr = a; in_src = s; in_write = w;
      in_be = BEP; in_xlat = x; in_fetch = f;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic sweep_one(input logic [AW-1:0] a, input logic [1:0] s, input bit w,
                            input bit x, input bit f);
      model(a, s, w, x, f);
      send(a, s, w, x, f);
      chk("R9 out_valid", 32'(out_valid), 32'd1);
      chk("R3/R5/R7 out_addr", 32'(out_addr), 32'(e_addr));
      chk("R3/R7 out_be", 32'(out_be), 32'(e_be));
      chk("R6 out_status", 32'(out_status), 32'(e_st));
      chk("R4 err_valid", 32'(err_valid), 32'(e_log));
      if (e_log) begin
         chk("R4 err_addr", 32'(err_addr), 32'(a));
         chk("R4 err_src", 32'(err_src), 32'(s));
      end
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
   endtask

   task automatic sweep_cfg();
      logic [AW-1:0] top, base;
      logic [AW-1:0] pts [16];
      top  = cfg_tolm - cfg_stolen;
      base = top - cfg_tseg_size;
      pts = '{24'h09_FFFF, 24'h0A_0000, 24'h0B_FFFF, 24'h0C_0000,
              24'h0F_FFFF, 24'h10_0000, base - 1, base, top - 1, top,
              cfg_aper_base - 1, cfg_aper_base, cfg_aper_limit - 1, cfg_aper_limit,
              24'h00_1000, 24'hFF_FFF0};
      foreach (pts[i])
         for (int s = 0; s < 4; s++)
            for (int k = 0; k < 8; k++)
               sweep_one(pts[i], 2'(s), k[0], k[1], k[2]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 out_valid", 32'(out_valid), 32'd0);
      chk("R10 err_valid", 32'(err_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // configuration A: both regions enabled
      cfg_compat_en = 1; cfg_tseg_en = 1;
      cfg_tolm = 24'h80_0000; cfg_stolen = 24'h10_0000; cfg_tseg_size = 24'h08_0000;
      cfg_aper_base = 24'h90_0000; cfg_aper_limit = 24'hA0_0000;
      sweep_cfg();

      // configuration B: top segment only, different placement
      cfg_compat_en = 0; cfg_tseg_en = 1;
      cfg_tolm = 24'h40_0000; cfg_stolen = 24'h0; cfg_tseg_size = 24'h10_0000;
      cfg_aper_base = 24'hC0_0000; cfg_aper_limit = 24'hC0_1000;
      sweep_cfg();

      // configuration C: both disabled (R1, R2 off; R7 still applies)
      cfg_compat_en = 0; cfg_tseg_en = 0;
      cfg_tolm = 24'h60_0000; cfg_stolen = 24'h08_0000; cfg_tseg_size = 24'h04_0000;
      sweep_cfg();

      // R8: first error kept
      cfg_compat_en = 1;
      send(24'h0A_1234, 2'd2, 1'b0, 1'b1, 1'b0);
      send(24'h0B_0000, 2'd0, 1'b1, 1'b1, 1'b0);
      chk("R8 sticky valid", 32'(err_valid), 32'd1);
      chk("R8 sticky addr", 32'(err_addr), 32'h0A_1234);
      chk("R8 sticky src", 32'(err_src), 32'd2);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      chk("R8 cleared", 32'(err_valid), 32'd0);

      // R8: clear colliding with a capture
      @(negedge clk);
      in_valid = 1; in_addr = 24'h0A_0040; in_src = 2'd1; in_write = 0; in_xlat = 1;
      in_fetch = 0; err_clr = 1;
      @(negedge clk);
      in_valid = 0; err_clr = 0;
      chk("R8 clear wins", 32'(err_valid), 32'd0);
      chk("R3 redirected during clear", 32'(out_addr), 32'(SAFE));

      // R9: backpressure and ordering
      @(negedge clk);
      out_ready = 0;
      in_valid = 1; in_addr = 24'h20_0000; in_src = 2'd0; in_write = 1; in_xlat = 0;
      in_fetch = 0;
      @(negedge clk);
      in_addr = 24'h21_0000;
      chk("R9 first out", 32'(out_addr), 32'h20_0000);
      chk("R9 stall ready", 32'(in_ready), 32'd0);
      repeat (3) begin
         @(negedge clk);
         chk("R9 held", 32'(out_addr), 32'h20_0000);
      end
      out_ready = 1;
      @(negedge clk);
      in_valid = 0;
      chk("R9 second out", 32'(out_addr), 32'h21_0000);
      chk("R9 second valid", 32'(out_valid), 32'd1);
      @(negedge clk);
      chk("R9 drained", 32'(out_valid), 32'd0);

      finish_run();
   end
endmodule